// File: doc/BRIEF.md
# Operand Address Generator with Alignment and Capacity Checks

This block turns the base, index and displacement parts of a storage operand reference into a 24-bit byte address. It checks that address in two ways. The first is operand alignment for the requested operand size. The second is whether every byte of the operand falls inside the storage that is actually installed.

The block drives two general-register read selects. It receives the two 32-bit register words back in the same cycle. Base, index and displacement are added modulo 2^24. The effective address, a misalignment (specification) flag and an out-of-storage (addressing) flag are registered together and appear one cycle after the request strobe. The results then hold until the next request.

Top module: `opnd_addr_gen`

## Requirements
- R1: The base term is bits 23:0 of the register named by the 4-bit base field. Bits 31:24 of that register have no effect on any output.
- R2: A base or index field of 0 adds zero to the sum, whatever register 0 holds.
- R3: The index register named by the index field is added only when `idx_en` is 1. When `idx_en` is 0, the index field has no effect.
- R4: The effective address is (base + index + zero-extended 12-bit displacement) mod 2^24. A sum past 16,777,215 wraps to low addresses without any flag.
- R5: Size codes 1 (halfword), 2 (word) and 3 (doubleword) need address bit 0, bits 1:0 and bits 2:0 respectively to be zero. If they are not, `spec_exc` is 1, unless `align_waive` is 1.
- R6: Size codes 0 (byte), 4 (variable length) and the unused codes 5 to 7 never raise `spec_exc`. Codes 5 to 7 are handled as a byte.
- R7: `addr_exc` is 1 when any operand byte lies at or above `cap_bytes`. The operand covers 1, 2, 4 or 8 bytes for codes 0 to 3, `var_len_m1`+1 bytes for code 4, and 1 byte for codes 5 to 7. A capacity of 0 flags every access.
- R8: An operand that runs past address 16,777,215 continues at address 0. It raises `addr_exc` only when `cap_bytes` is below 2^24. A `cap_bytes` of 2^24 or more never raises `addr_exc`.
- R9: `rsp_vld` is 1 exactly in the cycle after `req_vld`, and the address and both flags are updated then. Without a request, all outputs hold. Synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| base_fld | input | 4 | Base register field |
| idx_fld | input | 4 | Index register field |
| idx_en | input | 1 | Format carries an index field |
| disp | input | 12 | Unsigned displacement |
| size_code | input | 3 | 0 byte, 1 half, 2 word, 3 double, 4 variable |
| var_len_m1 | input | 8 | Variable operand length minus one |
| align_waive | input | 1 | Skip the alignment check |
| cap_bytes | input | 25 | Installed storage size in bytes |
| base_rsel | output | 4 | Register-file read select, base port |
| base_rdata | input | 32 | Register-file read data, base port |
| idx_rsel | output | 4 | Register-file read select, index port |
| idx_rdata | input | 32 | Register-file read data, index port |
| rsp_vld | output | 1 | Result valid |
| eff_addr | output | 24 | Effective address |
| spec_exc | output | 1 | Misalignment flag |
| addr_exc | output | 1 | Out-of-storage flag |

## Verification
The block keeps no state beyond its output registers. A fault in the sum, the checks or the capture shows up in the single response to the request that caused it, one cycle after the strobe. A capture that takes a register update when no request is present breaks the held value on the first idle cycle. The bench therefore compares every output on every clock against a behavioural model. The stimulus favours operands that end exactly at the capacity, straddle the top of storage, or sit one byte off alignment.

// File: rtl/opnd_ag_pkg.sv
package opnd_ag_pkg;
  typedef enum logic [2:0] {
    OPSZ_BYTE  = 3'd0,
    OPSZ_HALF  = 3'd1,
    OPSZ_WORD  = 3'd2,
    OPSZ_DWORD = 3'd3,
    OPSZ_VAR   = 3'd4
  } opsz_e;
endpackage

// File: rtl/ag_sum.sv
module ag_sum #(
  parameter int AW = 24,
  parameter int RW = 32,
  parameter int SW = 4,
  parameter int DW = 12
) (
  input  logic [SW-1:0] base_fld,
  input  logic [SW-1:0] idx_fld,
  input  logic          idx_en,
  input  logic [DW-1:0] disp,
  output logic [SW-1:0] base_rsel,
  input  logic [RW-1:0] base_rdata,
  output logic [SW-1:0] idx_rsel,
  input  logic [RW-1:0] idx_rdata,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] base_term, idx_term;
  logic          unused_hi;

  assign base_rsel = base_fld;
  assign idx_rsel  = idx_fld;

  // field value 0 means "no register", not register 0
  assign base_term = (base_fld == '0) ? '0 : base_rdata[AW-1:0];
  assign idx_term  = (idx_en && idx_fld != '0) ? idx_rdata[AW-1:0] : '0;

  // modulo 2^AW by truncation
  assign sum = base_term + idx_term + AW'(disp);

  assign unused_hi = ^{base_rdata[RW-1:AW], idx_rdata[RW-1:AW]};
endmodule

// File: rtl/ag_align.sv
module ag_align
  import opnd_ag_pkg::*;
(
  input  logic [2:0] addr_lo,
  input  opsz_e      size,
  input  logic       waive,
  output logic       misal
);
  logic raw;
  always_comb begin
    case (size)
      OPSZ_HALF:  raw = addr_lo[0];
      OPSZ_WORD:  raw = |addr_lo[1:0];
      OPSZ_DWORD: raw = |addr_lo;
      default:    raw = 1'b0;
    endcase
  end
  assign misal = raw & ~waive;
endmodule

// File: rtl/ag_limit.sv
module ag_limit
  import opnd_ag_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = 8
) (
  input  logic [AW-1:0] addr,
  input  opsz_e         size,
  input  logic [LW-1:0] len_m1,
  input  logic [AW:0]   cap,
  output logic          beyond
);
  localparam logic [AW:0] FULL = (AW+1)'(1) << AW;
  logic [AW:0] span_m1, last;

  always_comb begin
    case (size)
      OPSZ_HALF:  span_m1 = (AW+1)'(1);
      OPSZ_WORD:  span_m1 = (AW+1)'(3);
      OPSZ_DWORD: span_m1 = (AW+1)'(7);
      OPSZ_VAR:   span_m1 = (AW+1)'(len_m1);
      default:    span_m1 = '0;
    endcase
  end

  // unwrapped last byte; a straddle past the top shows as last >= FULL
  assign last   = {1'b0, addr} + span_m1;
  assign beyond = (cap < FULL) && (last >= cap);
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import opnd_ag_pkg::*;
#(
  parameter int AW   = 24,
  parameter int RW   = 32,
  parameter int NREG = 16,
  parameter int DW   = 12,
  parameter int LW   = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_vld,
  input  logic [SW-1:0] base_fld,
  input  logic [SW-1:0] idx_fld,
  input  logic          idx_en,
  input  logic [DW-1:0] disp,
  input  logic [2:0]    size_code,
  input  logic [LW-1:0] var_len_m1,
  input  logic          align_waive,
  input  logic [AW:0]   cap_bytes,
  output logic [SW-1:0] base_rsel,
  input  logic [RW-1:0] base_rdata,
  output logic [SW-1:0] idx_rsel,
  input  logic [RW-1:0] idx_rdata,
  output logic          rsp_vld,
  output logic [AW-1:0] eff_addr,
  output logic          spec_exc,
  output logic          addr_exc
);
  localparam logic [AW:0] FULL = (AW+1)'(1) << AW;

  opsz_e         size;
  logic [AW-1:0] sum;
  logic          misal, beyond;

  assign size = opsz_e'(size_code);

  ag_sum #(.AW(AW), .RW(RW), .SW(SW), .DW(DW)) u_sum (
    .base_fld(base_fld), .idx_fld(idx_fld), .idx_en(idx_en), .disp(disp),
    .base_rsel(base_rsel), .base_rdata(base_rdata),
    .idx_rsel(idx_rsel), .idx_rdata(idx_rdata), .sum(sum)
  );

  ag_align u_align (
    .addr_lo(sum[2:0]), .size(size), .waive(align_waive), .misal(misal)
  );

  ag_limit #(.AW(AW), .LW(LW)) u_limit (
    .addr(sum), .size(size), .len_m1(var_len_m1), .cap(cap_bytes), .beyond(beyond)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld  <= 1'b0;
      eff_addr <= '0;
      spec_exc <= 1'b0;
      addr_exc <= 1'b0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        eff_addr <= sum;
        spec_exc <= misal;
        addr_exc <= beyond;
      end
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> (!rsp_vld && $stable(eff_addr) && $stable(spec_exc) && $stable(addr_exc))); // R9
  AST_UNSIZED_NO_SPEC: assert property (@(posedge clk) disable iff (rst)
    (req_vld && (size_code == 3'd0 || size_code >= 3'd4)) |=> !spec_exc); // R6
  AST_WAIVE_NO_SPEC: assert property (@(posedge clk) disable iff (rst)
    (req_vld && align_waive) |=> !spec_exc); // R5
  AST_FULL_CAP_NO_AEXC: assert property (@(posedge clk) disable iff (rst)
    (req_vld && cap_bytes >= FULL) |=> !addr_exc); // R8
  AST_ZERO_FIELDS_DISP: assert property (@(posedge clk) disable iff (rst)
    (req_vld && base_fld == '0 && (!idx_en || idx_fld == '0))
      |=> (eff_addr == AW'($past(disp)))); // R2
  AST_ZERO_CAP_AEXC: assert property (@(posedge clk) disable iff (rst)
    (req_vld && cap_bytes == '0) |=> addr_exc); // R7
endmodule

// File: tb/opnd_addr_gen_tb.sv
module opnd_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0;
  logic [3:0]  base_fld = '0, idx_fld = '0;
  logic        idx_en = 1'b0;
  logic [11:0] disp = '0;
  logic [2:0]  size_code = '0;
  logic [7:0]  var_len_m1 = '0;
  logic        align_waive = 1'b0;
  logic [24:0] cap_bytes = 25'h1000000;
  logic [3:0]  base_rsel, idx_rsel;
  logic [31:0] base_rdata, idx_rdata;
  logic        rsp_vld, spec_exc, addr_exc;
  logic [23:0] eff_addr;

  logic [31:0] gr [16];
  assign base_rdata = gr[base_rsel];
  assign idx_rdata  = gr[idx_rsel];

  always #2 clk = ~clk;

  opnd_addr_gen u_dut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .base_fld(base_fld), .idx_fld(idx_fld),
    .idx_en(idx_en), .disp(disp), .size_code(size_code), .var_len_m1(var_len_m1),
    .align_waive(align_waive), .cap_bytes(cap_bytes),
    .base_rsel(base_rsel), .base_rdata(base_rdata),
    .idx_rsel(idx_rsel), .idx_rdata(idx_rdata),
    .rsp_vld(rsp_vld), .eff_addr(eff_addr), .spec_exc(spec_exc), .addr_exc(addr_exc)
  );

  int    vectors = 0, fails = 0, cycles = 0;
  bit    checking = 0;
  string cur_tag = "R9", e_tag = "R9";
  logic        e_vld = 0, e_spec = 0, e_aexc = 0;
  logic [23:0] e_addr = '0;

  // behavioural model, one response per strobe
  always @(posedge clk) begin
    longint b, x, a, n, last;
    if (rst) begin
      e_vld <= 0; e_addr <= '0; e_spec <= 0; e_aexc <= 0; e_tag <= "R9";
    end else begin
      e_vld <= req_vld;
      e_tag <= req_vld ? cur_tag : "R9";
      if (req_vld) begin
        b = (base_fld == 0) ? 0 : longint'(gr[base_fld] % 32'h1000000);
        x = (idx_en && idx_fld != 0) ? longint'(gr[idx_fld] % 32'h1000000) : 0;
        a = (b + x + longint'(disp)) % 64'h1000000;
        case (size_code)
          3'd1: n = 2; 3'd2: n = 4; 3'd3: n = 8;
          3'd4: n = longint'(var_len_m1) + 1;
          default: n = 1;
        endcase
        e_addr <= 24'(a);
        e_spec <= !align_waive && size_code >= 1 && size_code <= 3 && (a % n) != 0;
        last = a + n - 1;
        e_aexc <= (longint'(cap_bytes) < 64'h1000000) && (last >= longint'(cap_bytes));
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      if ({rsp_vld, eff_addr, spec_exc, addr_exc} !== {e_vld, e_addr, e_spec, e_aexc}) begin
        fails++;
        $display("FAIL %s: got vld=%0b addr=%h spec=%0b aexc=%0b, expected vld=%0b addr=%h spec=%0b aexc=%0b",
                 e_tag, rsp_vld, eff_addr, spec_exc, addr_exc, e_vld, e_addr, e_spec, e_aexc);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL R9: watchdog expired, got cycle %0d expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic issue(input logic [3:0] b, input logic [3:0] x, input logic hx,
                       input logic [11:0] d, input logic [2:0] sz, input logic [7:0] lm1,
                       input logic wv, input logic [24:0] cap, input string tag);
    @(negedge clk);
    req_vld = 1; base_fld = b; idx_fld = x; idx_en = hx; disp = d;
    size_code = sz; var_len_m1 = lm1; align_waive = wv; cap_bytes = cap; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_vld = 0; base_fld = 4'hF; disp = 12'hABC; cur_tag = "R9";
    end
  endtask

  localparam logic [24:0] FULL = 25'h1000000;

  initial begin
    for (int i = 0; i < 16; i++) gr[i] = {8'hA0 + 8'(i), 24'(i * 24'h010101)};
    gr[0] = 32'hFFFF_FFFF;
    gr[3] = 32'h55FF_FFF0;
    gr[5] = 32'h7E00_1000;
    gr[6] = 32'hC300_0003;
    repeat (3) @(negedge clk);
    rst = 0;
    checking = 1;                                        // reset state, R9
    issue(0, 0, 1, 12'h123, 0, 0, 0, FULL, "R2");        // both fields zero
    issue(0, 5, 0, 12'h010, 0, 0, 0, FULL, "R2");
    issue(5, 0, 0, 12'h000, 0, 0, 0, FULL, "R1");        // upper byte 7E ignored
    issue(3, 0, 0, 12'h004, 0, 0, 0, FULL, "R1");
    issue(5, 5, 0, 12'h004, 0, 0, 0, FULL, "R3");        // index off
    issue(5, 5, 1, 12'h004, 0, 0, 0, FULL, "R3");        // index on
    issue(3, 0, 0, 12'h020, 0, 0, 0, FULL, "R4");        // wraps to 000010
    issue(3, 3, 1, 12'hFFF, 0, 0, 0, FULL, "R4");
    idle(2);                                             // R9 hold
    issue(6, 0, 0, 12'h000, 1, 0, 0, FULL, "R5");        // half at odd
    issue(6, 0, 0, 12'h000, 1, 0, 1, FULL, "R5");        // waived
    issue(5, 0, 0, 12'h002, 2, 0, 0, FULL, "R5");        // word at +2
    issue(5, 0, 0, 12'h004, 3, 0, 0, FULL, "R5");        // double at +4
    issue(5, 0, 0, 12'h008, 3, 0, 0, FULL, "R5");        // double aligned
    issue(6, 0, 0, 12'h000, 0, 0, 0, FULL, "R6");
    issue(6, 0, 0, 12'h000, 4, 9, 0, FULL, "R6");
    issue(6, 0, 0, 12'h000, 7, 0, 0, FULL, "R6");
    issue(0, 0, 0, 12'hFFC, 2, 0, 0, 25'h1000, "R7");    // last byte FFF, inside
    issue(0, 0, 0, 12'hFFD, 1, 0, 0, 25'h1000, "R7");    // ends FFE, inside
    issue(0, 0, 0, 12'hFFE, 2, 0, 0, 25'h1000, "R7");    // straddles cap
    issue(0, 0, 0, 12'hFFD, 4, 3, 0, 25'h1000, "R7");    // variable, last 1000
    issue(0, 0, 0, 12'hFFD, 4, 2, 0, 25'h1000, "R7");    // variable, last FFF
    issue(5, 0, 0, 12'h000, 0, 0, 0, 25'h1000, "R7");    // start at cap
    issue(0, 0, 0, 12'h000, 0, 0, 0, 25'h0, "R7");       // zero capacity
    issue(3, 0, 0, 12'h00C, 4, 7, 0, FULL, "R8");        // straddle, full storage
    issue(3, 0, 0, 12'h00C, 4, 7, 0, 25'hFFFFFF, "R8");  // straddle, one short
    issue(3, 0, 0, 12'h00C, 4, 7, 0, 25'h1FFFFFF, "R8"); // above full
    issue(3, 0, 0, 12'h008, 3, 0, 0, 25'hFFFFFF, "R8");  // double ending at top
    idle(3);
    for (int k = 0; k < 400; k++) begin
      logic [24:0] cap;
      case ($urandom % 4)
        0: cap = FULL;
        1: cap = 25'($urandom % 32'h1000000);
        2: cap = 25'h1000 + 25'($urandom % 16);
        default: cap = 25'hFFFFF8 + 25'($urandom % 8);
      endcase
      if ($urandom % 5 == 0) idle(1);
      issue(4'($urandom), 4'($urandom), 1'($urandom), 12'($urandom), 3'($urandom),
            8'($urandom % 24), 1'($urandom % 4 == 0), cap, "R4");
    end
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule